// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is one channel of a down-counting timer that can also act as a pulse-width modulator. Two reload registers set the output: one gives the length of the low phase and the other the length of the high phase. A phase loaded with value N lasts N+1 clocks of the single input clock, so neither phase can be zero clocks long. The output can therefore never be held at 0% or 100% duty while it is running. Every time the counter reaches zero it sets an interrupt flag. That flag can be masked, and reading the end-of-interrupt location clears it.

Software reaches the channel through a plain register port: a write strobe, a read strobe, a byte address and a 32-bit data word. A parameter gives the channel index, and the channel's registers sit at fixed offsets derived from that index. In user mode the counter reloads from the register for the phase that comes next. In free-running mode it reloads with all ones, and the output stays low.

Top module: `pwm_chan_timer`

## Requirements
- R1: After reset both load registers, the control register, the current count and the interrupt status all read 0, and `pwm_out` and `irq` are low.
- R2: With B = 0x14 × CHAN, the low-phase load register is at B+0x00, the live count at B+0x04, control at B+0x08, end-of-interrupt at B+0x0C and interrupt status at B+0x10. The high-phase load register is at 0xB0 + 4 × CHAN. Both load registers read back the full 32 bits written. Control reads back only bits [3:0] (bit 0 enable, bit 1 user mode, bit 2 interrupt mask, bit 3 PWM output), and its upper bits read 0.
- R3: With control = 0xB and low load L, `pwm_out` first rises L+2 clocks after the clock edge that writes the enable bit. One of those clocks loads the counter and the other L+1 form the low phase. Every later low phase lasts L+1 clocks.
- R4: With high load H, each high phase of `pwm_out` lasts H+1 clocks.
- R5: While the channel is enabled the live count falls by one each clock. In user mode a count of zero is followed by the load value of the next phase (low, then high, then low again).
- R6: In free-running mode (bit 1 = 0) the counter loads 0xFFFFFFFF when enabled and then counts down, and `pwm_out` stays low even when bit 3 is set.
- R7: In user mode with bit 3 clear, `pwm_out` stays low while the counter runs.
- R8: Clearing the enable bit forces `pwm_out` low from the next clock and freezes the count. Enabling the channel again restarts it from the low phase, with the timing given in R3.
- R9: A load register written while the channel runs is not used until the next reload of its phase. The phase in progress keeps its length.
- R10: Each terminal count sets a raw flag. The status location reads the raw flag AND NOT the mask bit in bit 0, and `irq` shows that same value.
- R11: A read of the end-of-interrupt location clears the raw flag. If a terminal count falls in the same clock, the flag stays set.
- R12: Writes to the live count, status and end-of-interrupt locations, and to unmapped addresses, change nothing. Reads of unmapped addresses return 0.
- R13: With both loads at 0, `pwm_out` toggles every clock while it runs, giving the shortest period of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of end-of-interrupt clears the flag) |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the same cycle as reg_rd, 0 otherwise |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Masked interrupt |

## Verification
Two events can fall in the same clock: a terminal count that sets the interrupt flag and an end-of-interrupt read that clears it. The bench loads 0 into both reload registers, so a terminal count occurs on every clock while the channel runs, and then issues end-of-interrupt reads. It expects `irq` to stay high. It then disables the channel, waits until no terminal count can arrive, reads end-of-interrupt again and expects `irq` to drop. Load writes that arrive while a phase is running are checked by measuring the phase that follows.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int unsigned CTRL_W         = 4;
    localparam int unsigned CH_STRIDE      = 20;
    localparam int unsigned OFS_LOAD_LO    = 0;
    localparam int unsigned OFS_CUR        = 4;
    localparam int unsigned OFS_CTRL       = 8;
    localparam int unsigned OFS_EOI        = 12;
    localparam int unsigned OFS_STS        = 16;
    localparam int unsigned LOAD_HI_BASE   = 176;
    localparam int unsigned LOAD_HI_STRIDE = 4;

    // Field order matches the control bit positions: [3] pwm, [2] mask, [1] user, [0] enable
    typedef struct packed {
        logic pwm_on;
        logic irq_mask;
        logic user_mode;
        logic enable;
    } pwm_ctrl_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOAD_LO,
        SEL_CUR,
        SEL_CTRL,
        SEL_EOI,
        SEL_STS,
        SEL_LOAD_HI
    } reg_sel_e;

endpackage

// File: rtl/pwm_chan_decode.sv
module pwm_chan_decode
    import pwm_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CHAN   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int unsigned BASE = CHAN * CH_STRIDE;

    localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(BASE + OFS_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_CUR     = ADDR_W'(BASE + OFS_CUR);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(BASE + OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_EOI     = ADDR_W'(BASE + OFS_EOI);
    localparam logic [ADDR_W-1:0] A_STS     = ADDR_W'(BASE + OFS_STS);
    localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(LOAD_HI_BASE + CHAN * LOAD_HI_STRIDE);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_LOAD_LO) begin
            sel = SEL_LOAD_LO;
        end else if (addr == A_CUR) begin
            sel = SEL_CUR;
        end else if (addr == A_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr == A_EOI) begin
            sel = SEL_EOI;
        end else if (addr == A_STS) begin
            sel = SEL_STS;
        end else if (addr == A_LOAD_HI) begin
            sel = SEL_LOAD_HI;
        end
    end

endmodule

// File: rtl/pwm_chan_regfile.sv
module pwm_chan_regfile
    import pwm_chan_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc,
    input  logic [CNT_W-1:0]  cnt_val,
    output pwm_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  load_lo,
    output logic [CNT_W-1:0]  load_hi,
    output logic              irq_raw,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        pwm_ctrl_t        ctrl;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic             raw;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (sel)
                SEL_LOAD_LO: regs_d.lo   = wdata[CNT_W-1:0];
                SEL_LOAD_HI: regs_d.hi   = wdata[CNT_W-1:0];
                SEL_CTRL:    regs_d.ctrl = pwm_ctrl_t'(wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
        // Clear first, so that a terminal count in the same cycle keeps the flag set
        if (rd && (sel == SEL_EOI)) begin
            regs_d.raw = 1'b0;
        end
        if (tc) begin
            regs_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl    = regs_q.ctrl;
    assign load_lo = regs_q.lo;
    assign load_hi = regs_q.hi;
    assign irq_raw = regs_q.raw;
    assign irq     = regs_q.raw & ~regs_q.ctrl.irq_mask;

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_LOAD_LO: rdata = DATA_W'(regs_q.lo);
                SEL_LOAD_HI: rdata = DATA_W'(regs_q.hi);
                SEL_CUR:     rdata = DATA_W'(cnt_val);
                SEL_CTRL:    rdata = DATA_W'(regs_q.ctrl);
                SEL_STS:     rdata = DATA_W'(irq);
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
    import pwm_chan_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_lo,
    input  logic [CNT_W-1:0] load_hi,
    output logic [CNT_W-1:0] cnt_val,
    output phase_e           phase,
    output logic             running,
    output logic             tc,
    output logic             pwm_out
);

    localparam logic [CNT_W-1:0] FREE_RELOAD = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        phase_e           phase;
        logic             run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] reload_lo, reload_hi;

    always_comb begin
        reload_lo = ctrl.user_mode ? load_lo : FREE_RELOAD;
        reload_hi = ctrl.user_mode ? load_hi : FREE_RELOAD;
        st_d      = st_q;
        tc        = 1'b0;
        if (!ctrl.enable) begin
            // Hold the count; the next enable starts a fresh low phase
            st_d.run   = 1'b0;
            st_d.phase = PH_LOW;
        end else if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.phase = PH_LOW;
            st_d.cnt   = reload_lo;
        end else if (st_q.cnt == '0) begin
            tc = 1'b1;
            if (st_q.phase == PH_LOW) begin
                st_d.phase = PH_HIGH;
                st_d.cnt   = reload_hi;
            end else begin
                st_d.phase = PH_LOW;
                st_d.cnt   = reload_lo;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, phase: PH_LOW, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_val = st_q.cnt;
    assign phase   = st_q.phase;
    assign running = st_q.run;
    assign pwm_out = ctrl.enable & st_q.run & ctrl.pwm_on & ctrl.user_mode
                   & (st_q.phase == PH_HIGH);

endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
    import pwm_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned CHAN   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out,
    output logic              irq
);

    reg_sel_e         sel;
    pwm_ctrl_t        ctrl;
    logic [CNT_W-1:0] load_lo, load_hi, cnt_val;
    phase_e           cnt_phase;
    logic             cnt_run, cnt_tc, irq_raw;
    logic             phase_hi, ctrl_en;

    assign phase_hi = (cnt_phase == PH_HIGH);
    assign ctrl_en  = ctrl.enable;

    pwm_chan_decode #(
        .ADDR_W (ADDR_W),
        .CHAN   (CHAN)
    ) i_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    pwm_chan_regfile #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .sel     (sel),
        .wdata   (reg_wdata),
        .tc      (cnt_tc),
        .cnt_val (cnt_val),
        .ctrl    (ctrl),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .irq_raw (irq_raw),
        .irq     (irq),
        .rdata   (reg_rdata)
    );

    pwm_chan_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .cnt_val (cnt_val),
        .phase   (cnt_phase),
        .running (cnt_run),
        .tc      (cnt_tc),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker
    import pwm_chan_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned CHAN   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wd_en_bit,
    input logic              wd_mask_bit,
    input logic              pwm_out,
    input logic              irq,
    input logic              tc,
    input logic              irq_raw,
    input logic [CNT_W-1:0]  cnt,
    input logic              phase_hi,
    input logic              running,
    input logic              enable
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CHAN * CH_STRIDE + OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(CHAN * CH_STRIDE + OFS_EOI);

    logic ctrl_wr, eoi_rd;
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign eoi_rd  = reg_rd && (reg_addr == A_EOI);

    p_off_output_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wd_en_bit) |=> !pwm_out);

    p_disabled_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt));

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wd_mask_bit) |=> !irq);

    p_tc_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> irq_raw);

    p_eoi_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_rd && !tc) |=> !irq_raw);

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && (cnt != '0)) |=> (cnt == ($past(cnt) - 1'b1)));

    p_tc_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (running && (cnt == '0)));

    p_phase_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (phase_hi != $past(phase_hi)));

endmodule

bind pwm_chan_timer pwm_chan_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CHAN   (CHAN)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .wd_en_bit   (reg_wdata[0]),
    .wd_mask_bit (reg_wdata[2]),
    .pwm_out     (pwm_out),
    .irq         (irq),
    .tc          (cnt_tc),
    .irq_raw     (irq_raw),
    .cnt         (cnt_val),
    .phase_hi    (phase_hi),
    .running     (cnt_run),
    .enable      (ctrl_en)
);

// File: tb/test_pwm_chan_timer.sv
module test_pwm_chan_timer;

    localparam int unsigned CH = 2;
    localparam logic [7:0] A_LO   = 8'h28;
    localparam logic [7:0] A_CUR  = 8'h2C;
    localparam logic [7:0] A_CTRL = 8'h30;
    localparam logic [7:0] A_EOI  = 8'h34;
    localparam logic [7:0] A_STS  = 8'h38;
    localparam logic [7:0] A_HI   = 8'hB8;

    // {low load, high load, expected rise delay, expected high width, expected low width}
    localparam int NVEC = 6;
    localparam logic [79:0] VEC [NVEC] = '{
        {16'd0, 16'd0, 16'd2, 16'd1,  16'd1},
        {16'd1, 16'd0, 16'd3, 16'd1,  16'd2},
        {16'd0, 16'd3, 16'd2, 16'd4,  16'd1},
        {16'd4, 16'd2, 16'd6, 16'd3,  16'd5},
        {16'd7, 16'd7, 16'd9, 16'd8,  16'd8},
        {16'd2, 16'd9, 16'd4, 16'd10, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out, irq;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pwm_chan_timer #(
        .ADDR_W (8),
        .DATA_W (32),
        .CNT_W  (32),
        .CHAN   (CH)
    ) i_pwm_chan_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd   = 1'b1;
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_rise(output int k);
        k = 0;
        while (!pwm_out && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic width(input logic lvl, output int k);
        k = 0;
        while ((pwm_out == lvl) && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual >=150000 cycles expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int k;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_LO, v);   check("R1", "low load", v, 32'h0);
        rd(A_HI, v);   check("R1", "high load", v, 32'h0);
        rd(A_CTRL, v); check("R1", "control", v, 32'h0);
        rd(A_CUR, v);  check("R1", "count", v, 32'h0);
        rd(A_STS, v);  check("R1", "status", v, 32'h0);
        check("R1", "pwm_out", 32'(pwm_out), 32'h0);
        check("R1", "irq", 32'(irq), 32'h0);

        // R2 offsets and readback
        wr(A_LO, 32'h1234_5678);
        wr(A_HI, 32'h9ABC_DEF0);
        wr(A_CTRL, 32'hFFFF_FFF6);
        rd(A_LO, v);   check("R2", "low load readback", v, 32'h1234_5678);
        rd(A_HI, v);   check("R2", "high load readback", v, 32'h9ABC_DEF0);
        rd(A_CTRL, v); check("R2", "control readback", v, 32'h6);

        // R12 read-only and unmapped locations
        rd(A_CUR, v2);
        wr(A_CUR, 32'hFFFF_FFFF);
        wr(A_STS, 32'hFFFF_FFFF);
        wr(A_EOI, 32'hFFFF_FFFF);
        wr(8'h00, 32'h5555_5555);
        wr(8'hFC, 32'h5555_5555);
        rd(A_CUR, v);  check("R12", "count after write", v, v2);
        rd(A_STS, v);  check("R12", "status after write", v, 32'h0);
        rd(A_LO, v);   check("R12", "low load after foreign write", v, 32'h1234_5678);
        rd(A_HI, v);   check("R12", "high load after foreign write", v, 32'h9ABC_DEF0);
        rd(A_CTRL, v); check("R12", "control after foreign write", v, 32'h6);
        rd(8'h00, v);  check("R12", "unmapped read 0x00", v, 32'h0);
        rd(8'hFC, v);  check("R12", "unmapped read 0xFC", v, 32'h0);

        // R3 R4 R13 vector table: phase widths
        for (int i = 0; i < NVEC; i++) begin
            int rise, hw, lw;
            wr(A_CTRL, 32'h0A);
            wr(A_LO, 32'(VEC[i][79:64]));
            wr(A_HI, 32'(VEC[i][63:48]));
            wr(A_CTRL, 32'h0B);
            wait_rise(rise);
            check("R3", $sformatf("first rise vec %0d", i), 32'(rise), 32'(VEC[i][47:32]));
            width(1'b1, hw);
            check("R4", $sformatf("high width vec %0d", i), 32'(hw), 32'(VEC[i][31:16]));
            width(1'b0, lw);
            check("R3", $sformatf("low width vec %0d", i), 32'(lw), 32'(VEC[i][15:0]));
            width(1'b1, hw);
            check("R13", $sformatf("second high width vec %0d", i), 32'(hw), 32'(VEC[i][31:16]));
        end

        // R5 R7 R10 R11 countdown, reload and interrupt
        wr(A_CTRL, 32'h0);
        wr(A_LO, 32'd5);
        wr(A_HI, 32'd20);
        wr(A_EOI, 32'h0);
        rd(A_EOI, v);
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        rd(A_CUR, v);  check("R5", "count after load", v, 32'd5);
        rd(A_CUR, v);  check("R5", "count decrements", v, 32'd4);
        repeat (4) @(negedge clk);
        rd(A_CUR, v);  check("R5", "reload from high load", v, 32'd20);
        check("R10", "irq after terminal count", 32'(irq), 32'h1);
        check("R7", "pwm_out with PWM bit clear", 32'(pwm_out), 32'h0);
        rd(A_STS, v);  check("R10", "status set", v, 32'h1);
        rd(A_EOI, v);
        check("R11", "irq after EOI read", 32'(irq), 32'h0);
        wr(A_CTRL, 32'h7);
        repeat (20) @(negedge clk);
        check("R10", "irq masked", 32'(irq), 32'h0);
        rd(A_STS, v);  check("R10", "status masked", v, 32'h0);
        wr(A_CTRL, 32'h3);
        check("R10", "irq after unmask", 32'(irq), 32'h1);

        // R11 EOI read in the same cycle as a terminal count
        wr(A_CTRL, 32'h0);
        wr(A_LO, 32'd0);
        wr(A_HI, 32'd0);
        wr(A_CTRL, 32'h3);
        repeat (3) @(negedge clk);
        rd(A_EOI, v);
        rd(A_EOI, v);
        check("R11", "irq kept when terminal count coincides", 32'(irq), 32'h1);
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        rd(A_EOI, v);
        check("R11", "irq cleared once idle", 32'(irq), 32'h0);

        // R8 disable mid-phase, freeze and restart
        wr(A_CTRL, 32'h0A);
        wr(A_LO, 32'd10);
        wr(A_HI, 32'd10);
        wr(A_CTRL, 32'h0B);
        wait_rise(k);
        wr(A_CTRL, 32'h0A);
        check("R8", "pwm_out low after disable", 32'(pwm_out), 32'h0);
        rd(A_CUR, v);
        rd(A_CUR, v2);
        check("R8", "count frozen", v2, v);
        repeat (5) @(negedge clk);
        check("R8", "pwm_out stays low", 32'(pwm_out), 32'h0);
        wr(A_CTRL, 32'h0B);
        wait_rise(k);
        check("R8", "rise after re-enable", 32'(k), 32'd12);

        // R9 load write while running
        wr(A_CTRL, 32'h0A);
        wr(A_LO, 32'd3);
        wr(A_HI, 32'd3);
        wr(A_CTRL, 32'h0B);
        wait_rise(k);
        wr(A_LO, 32'd8);
        width(1'b1, k);
        check("R9", "high phase unaffected", 32'(k), 32'd3);
        width(1'b0, k);
        check("R9", "next low uses new load", 32'(k), 32'd9);

        // R6 free-running mode
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h9);
        @(negedge clk);
        rd(A_CUR, v);  check("R6", "free-running load", v, 32'hFFFF_FFFF);
        rd(A_CUR, v);  check("R6", "free-running decrement", v, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        check("R6", "pwm_out low in free-running mode", 32'(pwm_out), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule